// File: doc/BRIEF.md
# Dual Wiper Serial Control Interface

This block is the serial command front end of a two-channel programmable resistor controller. A host shifts a 24-bit command frame into it over a three-wire serial port, which has a bit clock, a data input and an active-low select. The frame is executed when the select line goes back high. The block keeps two 10-bit wiper registers. It also keeps a bank of non-volatile shadow words, modelled as a register array, and a store takes a programming time that is modelled by a busy timer. The serial port is sampled in the system clock domain: a bit is taken on each rising edge of the serial clock that the system clock detects.

The serial output has two roles. After one of the two read commands, it returns the selected value during the next frame. For every other command, it returns the previous frame, delayed by exactly 24 serial clocks, so that several devices can be chained. An active-low write-protect input blocks every command that would change stored state. A preset input reloads both wipers from the shadow on its rising edge. A ready output is low while a store, a restore, a read or a preset is in progress, and any frame that completes during that time is discarded.

Top module: `dws_serial_ctrl`

## Requirements
- R1: A frame is taken MSB first, one bit on each detected rising edge of `ser_clk` while `ser_cs_n` is low. On the rising edge of `ser_cs_n`, the last 24 bits are decoded as op = bits [23:20], addr = bits [19:16] and data = bits [15:0], provided at least 24 bits were shifted. A frame with fewer bits is discarded.
- R2: After reset, both wipers and every shadow word hold 0x200, `ready` is high and `ser_dout` is low.
- R3: Op 11 writes data[9:0] into wiper 0 (addr 0) or wiper 1 (addr 1). The wiper ops 1, 2, 10 and 11 do nothing when addr is 2 or more.
- R4: Op 1 copies shadow word addr[0] into wiper addr[0]. Op 8 copies shadow words 0 and 1 into wipers 0 and 1.
- R5: Op 2 copies wiper addr into shadow word addr. Op 3 writes data[15:0] into shadow word addr. Both ops hold `ready` low for exactly STORE_CYCLES clock cycles, starting in the cycle after the frame is taken.
- R6: While `wp_n` is low, ops 1, 2, 3, 8 and 11 change nothing and leave `ready` high. Ops 9 and 10 still read, and the preset still reloads the wipers.
- R7: Any frame that completes while `ready` is low is discarded.
- R8: Ops 8, 9 and 10 and a preset hold `ready` low for RESTORE_CYCLES cycles. Ops 2 and 3 hold it low as stated in R5. Ops 0, 1 and 11 and unassigned op codes leave `ready` high.
- R9: Op 9 loads the word {op, addr, shadow[addr]} for readback. Op 10 loads {op, addr, zero-extended wiper[addr]}. During the next frame, this 24-bit word appears on `ser_dout` MSB first. Each bit is valid before the serial clock edge that shifts it out.
- R10: After any other frame, including a discarded one, `ser_dout` shifts out that frame's 24 bits MSB first during the next frame.
- R11: A low-to-high change of `preset` reloads wiper 0 and wiper 1 from shadow words 0 and 1. The input is treated as high during reset. The preset is ignored while `ready` is low, and it wins over a frame that completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, sampled by clk |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_cs_n | input | 1 | Active-low frame select |
| ser_dout | output | 1 | Readback or chained frame output |
| wp_n | input | 1 | Active-low write protect |
| preset | input | 1 | Reload wipers from shadow on rising edge |
| ready | output | 1 | High when no operation is in progress |
| wiper0 | output | 10 | Wiper register 0 |
| wiper1 | output | 10 | Wiper register 1 |

## Verification
The hardest case to reach from the ports is a frame that arrives while a store is still running. To reach it, the bench starts a store with a long programming time. It then shifts a complete write frame and raises the select line before `ready` returns. The bench confirms that `ready` was still low when that frame ended, and then that the wiper stayed unchanged. A second hard case is showing that a protected store really refused to write the shadow. The bench shows this indirectly: a later preset reloads the old shadow value into a wiper that had been changed in the meantime.

// File: rtl/dws_pkg.sv
package dws_pkg;
  localparam int FRAME_W = 24;
  localparam int OP_W    = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;

  typedef enum logic [OP_W-1:0] {
    OP_NOP         = 4'd0,
    OP_RESTORE     = 4'd1,
    OP_STORE       = 4'd2,
    OP_STORE_USER  = 4'd3,
    OP_RESTORE_ALL = 4'd8,
    OP_READ_NV     = 4'd9,
    OP_READ_WIPER  = 4'd10,
    OP_WRITE       = 4'd11
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dws_shifter.sv
module dws_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               cs_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  output logic               frame_valid,
  output logic [FRAME_W-1:0] frame_word,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic               sclk_q;
  logic               cs_q;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               shift_en;

  assign shift_en = sclk & ~sclk_q & ~cs_n;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_word;
    end else if (shift_en) begin
      sh_d = {sh_q[FRAME_W-2:0], sdi};
    end
    cnt_d = cnt_q;
    if (cs_n) begin
      cnt_d = '0;
    end else if (shift_en && (cnt_q != CNT_W'(FRAME_W))) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  // frame ends when select rises after at least a full frame of bits
  assign frame_valid = cs_n & ~cs_q & (cnt_q == CNT_W'(FRAME_W));
  assign frame_word  = sh_q;
  assign sdo         = sh_q[FRAME_W-1];
endmodule

// File: rtl/dws_busy_timer.sv
module dws_busy_timer #(
  parameter int LONG_CYCLES  = 400,
  parameter int SHORT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_long,
  input  logic start_short,
  output logic busy
);
  localparam int MAX_CYC = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_long) begin
      cnt_d = CNT_W'(LONG_CYCLES);
    end else if (start_short) begin
      cnt_d = CNT_W'(SHORT_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dws_core.sv
module dws_core
  import dws_pkg::*;
#(
  parameter int WIPER_W   = 10,
  parameter int NUM_WORDS = 16,
  parameter int MID_VALUE = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               busy,
  input  logic               wp_n,
  input  logic               preset,
  output logic               start_long,
  output logic               start_short,
  output logic               rb_load,
  output logic [FRAME_W-1:0] rb_word,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1
);
  localparam int AW = $clog2(NUM_WORDS);

  frame_t             f;
  logic [WIPER_W-1:0] wiper_q  [2];
  logic [WIPER_W-1:0] wiper_d  [2];
  logic [DATA_W-1:0]  shadow_q [NUM_WORDS];
  logic [DATA_W-1:0]  shadow_d [NUM_WORDS];
  logic               preset_q;
  logic               pr_go, go, wsel_ok, nv_ok, wsel;
  logic [AW-1:0]      nv_idx;

  assign f       = frame_t'(frame_word);
  assign pr_go   = preset & ~preset_q & ~busy;
  assign go      = frame_valid & ~busy & ~pr_go;
  assign wsel_ok = (f.addr < ADDR_W'(2));
  assign nv_ok   = (int'(f.addr) < NUM_WORDS);
  assign wsel    = f.addr[0];
  assign nv_idx  = AW'(f.addr);

  always_comb begin
    wiper_d     = wiper_q;
    shadow_d    = shadow_q;
    start_long  = 1'b0;
    start_short = 1'b0;
    rb_load     = 1'b0;
    rb_word     = {f.op, f.addr, {DATA_W{1'b0}}};
    if (pr_go) begin
      wiper_d[0]  = shadow_q[0][WIPER_W-1:0];
      wiper_d[1]  = shadow_q[1][WIPER_W-1:0];
      start_short = 1'b1;
    end else if (go) begin
      case (f.op)
        OP_RESTORE: begin
          if (wp_n && wsel_ok) wiper_d[wsel] = shadow_q[nv_idx][WIPER_W-1:0];
        end
        OP_STORE: begin
          if (wp_n && wsel_ok) begin
            shadow_d[nv_idx] = DATA_W'(wiper_q[wsel]);
            start_long       = 1'b1;
          end
        end
        OP_STORE_USER: begin
          if (wp_n && nv_ok) begin
            shadow_d[nv_idx] = f.data;
            start_long       = 1'b1;
          end
        end
        OP_RESTORE_ALL: begin
          if (wp_n) begin
            wiper_d[0]  = shadow_q[0][WIPER_W-1:0];
            wiper_d[1]  = shadow_q[1][WIPER_W-1:0];
            start_short = 1'b1;
          end
        end
        OP_READ_NV: begin
          if (nv_ok) begin
            rb_load     = 1'b1;
            rb_word     = {f.op, f.addr, shadow_q[nv_idx]};
            start_short = 1'b1;
          end
        end
        OP_READ_WIPER: begin
          if (wsel_ok) begin
            rb_load     = 1'b1;
            rb_word     = {f.op, f.addr, DATA_W'(wiper_q[wsel])};
            start_short = 1'b1;
          end
        end
        OP_WRITE: begin
          if (wp_n && wsel_ok) wiper_d[wsel] = f.data[WIPER_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= 1'b1;
      for (int i = 0; i < 2; i++) wiper_q[i] <= WIPER_W'(MID_VALUE);
      for (int i = 0; i < NUM_WORDS; i++) shadow_q[i] <= DATA_W'(MID_VALUE);
    end else begin
      preset_q <= preset;
      wiper_q  <= wiper_d;
      shadow_q <= shadow_d;
    end
  end

  assign wiper0 = wiper_q[0];
  assign wiper1 = wiper_q[1];
endmodule

// File: rtl/dws_serial_ctrl.sv
module dws_serial_ctrl
  import dws_pkg::*;
#(
  parameter int STORE_CYCLES   = 400,
  parameter int RESTORE_CYCLES = 3,
  parameter int WIPER_W        = 10,
  parameter int NUM_WORDS      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_din,
  input  logic               ser_cs_n,
  output logic               ser_dout,
  input  logic               wp_n,
  input  logic               preset,
  output logic               ready,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1
);
  logic               frame_valid;
  logic [FRAME_W-1:0] frame_word;
  logic               rb_load;
  logic [FRAME_W-1:0] rb_word;
  logic               busy;
  logic               start_long, start_short;

  dws_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (ser_clk),
    .sdi         (ser_din),
    .cs_n        (ser_cs_n),
    .load        (rb_load),
    .load_word   (rb_word),
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .sdo         (ser_dout)
  );

  dws_core #(
    .WIPER_W   (WIPER_W),
    .NUM_WORDS (NUM_WORDS),
    .MID_VALUE (1 << (WIPER_W - 1))
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .busy        (busy),
    .wp_n        (wp_n),
    .preset      (preset),
    .start_long  (start_long),
    .start_short (start_short),
    .rb_load     (rb_load),
    .rb_word     (rb_word),
    .wiper0      (wiper0),
    .wiper1      (wiper1)
  );

  dws_busy_timer #(
    .LONG_CYCLES  (STORE_CYCLES),
    .SHORT_CYCLES (RESTORE_CYCLES)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_long  (start_long),
    .start_short (start_short),
    .busy        (busy)
  );

  assign ready = ~busy;
endmodule

// File: rtl/dws_serial_ctrl_chk.sv
module dws_serial_ctrl_chk #(
  parameter int WIPER_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               wp_n,
  input logic               preset,
  input logic               frame_valid,
  input logic [23:0]        frame_word,
  input logic [WIPER_W-1:0] wiper0,
  input logic [WIPER_W-1:0] wiper1
);
  assert_busy_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(wiper0) && $stable(wiper1)));

  assert_wp_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && !preset) |=> ($stable(wiper0) && $stable(wiper1)));

  assert_store_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && ready && wp_n && frame_word[23:20] == 4'd2 && frame_word[19:16] < 4'd2)
    |=> !ready);

  assert_ready_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(frame_valid) || $past(preset)));

  assert_write_w0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && ready && wp_n && !preset && frame_word[23:16] == 8'hB0)
    |=> (wiper0 == $past(frame_word[WIPER_W-1:0])));
endmodule

bind dws_serial_ctrl dws_serial_ctrl_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (ready),
  .wp_n        (wp_n),
  .preset      (preset),
  .frame_valid (frame_valid),
  .frame_word  (frame_word),
  .wiper0      (wiper0),
  .wiper1      (wiper1)
);

// File: tb/dws_serial_ctrl_tb.sv
module dws_serial_ctrl_tb;
  localparam int STORE_CYC = 400;
  localparam int REST_CYC  = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_din, ser_cs_n, wp_n, preset;
  logic       ser_dout, ready;
  logic [9:0] wiper0, wiper1;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;

  always #10 clk = ~clk;

  dws_serial_ctrl #(.STORE_CYCLES(STORE_CYC), .RESTORE_CYCLES(REST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_cs_n(ser_cs_n), .ser_dout(ser_dout), .wp_n(wp_n), .preset(preset),
    .ready(ready), .wiper0(wiper0), .wiper1(wiper1)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog all requirements actual=%0d cycles expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [23:0] frame;
    logic        wp;
    logic [3:0]  req;
    logic [9:0]  w0;
    logic [9:0]  w1;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{24'hB00155, 1'b1, 4'd3,  10'h155, 10'h200},  // R3 write wiper 0
    '{24'hB103FF, 1'b1, 4'd3,  10'h155, 10'h3FF},  // R3 write wiper 1
    '{24'hB20123, 1'b1, 4'd3,  10'h155, 10'h3FF},  // R3 addr 2 ignored
    '{24'h200000, 1'b1, 4'd5,  10'h155, 10'h3FF},  // R5 store wiper 0
    '{24'hB00000, 1'b1, 4'd3,  10'h000, 10'h3FF},  // R3
    '{24'h100000, 1'b1, 4'd4,  10'h155, 10'h3FF},  // R4 restore wiper 0
    '{24'hB00077, 1'b0, 4'd6,  10'h155, 10'h3FF},  // R6 protected write
    '{24'h800000, 1'b0, 4'd6,  10'h155, 10'h3FF},  // R6 protected restore all
    '{24'h800000, 1'b1, 4'd4,  10'h155, 10'h200},  // R4 restore all
    '{24'hB1FFFF, 1'b1, 4'd3,  10'h155, 10'h3FF},  // R3 low 10 bits only
    '{24'h000000, 1'b1, 4'd8,  10'h155, 10'h3FF},  // R8 no-op
    '{24'h3105AA, 1'b1, 4'd5,  10'h155, 10'h3FF},  // R5 user word into shadow 1
    '{24'h110000, 1'b1, 4'd4,  10'h155, 10'h1AA}   // R4 restore wiper 1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input int nbits, output logic [23:0] rx);
    rx = '0;
    @(negedge clk) ser_cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      ser_din = w[nbits-1-i];
      rx = {rx[22:0], ser_dout};
      @(negedge clk) ser_clk = 1'b1;
      @(negedge clk) ser_clk = 1'b0;
    end
    @(negedge clk) ser_cs_n = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (2) @(negedge clk);
    while (ready !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ready_stays_high(input string tag);
    logic seen_low = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (ready !== 1'b1) seen_low = 1'b1;
    end
    chk(tag, {31'b0, seen_low}, 32'd0);
  endtask

  logic [23:0] rx;
  int          lowcnt;
  logic        rdy_at_end, saw_low;

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; ser_cs_n = 1'b1;
    wp_n = 1'b1; preset = 1'b0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 ready after reset", {31'b0, ready}, 32'd1);
    chk("R2 wiper0 after reset", {22'b0, wiper0}, 32'h200);
    chk("R2 wiper1 after reset", {22'b0, wiper1}, 32'h200);
    chk("R2 dout after reset", {31'b0, ser_dout}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 13; k++) begin
      wp_n = VECS[k].wp;
      send({8'b0, VECS[k].frame}, 24, rx);
      wait_idle();
      checks++;
      if (wiper0 !== VECS[k].w0 || wiper1 !== VECS[k].w1) begin
        errors++;
        $display("FAIL table[%0d] R%0d actual=%h/%h expected=%h/%h",
                 k, VECS[k].req, wiper0, wiper1, VECS[k].w0, VECS[k].w1);
      end
    end
    wp_n = 1'b1;

    // R9 readback of shadow word 1
    send(32'h910000, 24, rx); wait_idle();
    send(32'h000000, 24, rx); wait_idle();
    chk("R9 read shadow 1", {8'b0, rx}, 32'h9105AA);

    // R10 chained output of an unassigned op; R8 ready stays high
    send(32'hC3A5F0, 24, rx);
    ready_stays_high("R8 unassigned op keeps ready");
    send(32'h000000, 24, rx); wait_idle();
    chk("R10 chained frame", {8'b0, rx}, 32'hC3A5F0);

    // R6 read wiper works under write protect
    wp_n = 1'b0;
    send(32'hA00000, 24, rx); wait_idle();
    send(32'h000000, 24, rx); wait_idle();
    chk("R6 R9 read wiper 0 protected", {8'b0, rx}, 32'hA00155);
    wp_n = 1'b1;

    // R8 write keeps ready high
    send(32'hB00010, 24, rx);
    ready_stays_high("R8 write keeps ready");
    chk("R3 wiper0 write", {22'b0, wiper0}, 32'h010);

    // R5 store duration
    send(32'h350042, 24, rx);
    lowcnt = 0;
    @(negedge clk);
    while (ready === 1'b0 && lowcnt < 2000) begin
      lowcnt++;
      @(negedge clk);
    end
    chk("R5 store busy cycles", lowcnt, STORE_CYC);

    // R6 protected store: no busy, shadow 0 kept (proved by the preset below)
    wp_n = 1'b0;
    send(32'h200000, 24, rx);
    ready_stays_high("R6 protected store keeps ready");
    wp_n = 1'b1;

    // R7 frame during busy is discarded
    send(32'h210000, 24, rx);
    repeat (2) @(negedge clk);
    send(32'hB00333, 24, rx);
    @(negedge clk) rdy_at_end = ready;
    chk("R7 still busy at frame end", {31'b0, rdy_at_end}, 32'd0);
    wait_idle();
    chk("R7 wiper0 unchanged", {22'b0, wiper0}, 32'h010);

    // R11 preset under write protect
    send(32'hB100AB, 24, rx); wait_idle();
    wp_n = 1'b0;
    @(negedge clk) preset = 1'b1;
    saw_low = 1'b0;
    repeat (2) begin
      @(negedge clk);
      if (ready === 1'b0) saw_low = 1'b1;
    end
    wait_idle();
    chk("R8 preset drops ready", {31'b0, saw_low}, 32'd1);
    chk("R11 R6 preset wiper0", {22'b0, wiper0}, 32'h155);
    chk("R11 preset wiper1", {22'b0, wiper1}, 32'h1AA);
    preset = 1'b0; wp_n = 1'b1;

    // R1 short frame discarded, long frame uses last 24 bits
    send(32'h000B0000 >> 4, 20, rx); wait_idle();
    chk("R1 short frame ignored", {22'b0, wiper0}, 32'h155);
    send(32'h01B00099, 25, rx); wait_idle();
    chk("R1 25-bit frame last 24", {22'b0, wiper0}, 32'h099);

    // R2 reset again, shadow back to midscale
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R2 wiper0 reset", {22'b0, wiper0}, 32'h200);
    chk("R2 ready reset", {31'b0, ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    send(32'h900000, 24, rx); wait_idle();
    send(32'h000000, 24, rx); wait_idle();
    chk("R2 shadow 0 midscale", {8'b0, rx}, 32'h900200);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule